// File: doc/BRIEF.md
# Serial LCD Command and Display-Data Receiver

This block is the host-facing receiver of a segment LCD controller. A host drives three wires: an active-low select, a shift clock and a data line. The block samples these in the controller's own clock domain and packs the bits into 8-bit words. The first word of every select-low burst decides what the burst means. An address word opens a stream of display bytes that fill a 64-byte display memory through a self-incrementing pointer. Either of two command words loads a 6-bit configuration register, and any words that follow it in the same burst are dropped.

The display side reads the memory through a combinational read port and receives the configuration already decoded. That includes the number of active common lines, the bias choice, a mask of segment outputs turned into general-purpose ports, the oscillator source, the waveform type, the contrast code and display enable. An asynchronous active-low reset restores every default and clears the memory.

A burst finite-state machine with four states controls the burst:
- **IDLE**: the select line is high. The falling edge of select moves to **FIRST**.
- **FIRST**: the first word is being received. When that word completes, an address word moves to **DATA**. A command word, or a word with the unused type 00, moves to **SKIP**.
- **DATA**: each completed word is written to the display memory.
- **SKIP**: completed words are discarded.
- From FIRST, DATA and SKIP, the rising edge of select returns to **IDLE**. That edge takes priority over the word-type transition.

Top module: `lcd_serial_if`

## Requirements
- R1: After reset, all configuration outputs show their defaults and every memory byte reads 0. The defaults are: com_count = 4, bias_half = 0, port_mask = 0000, osc_ext = 0, wave_b = 0, contrast = 000 and disp_on = 0.
- R2: A bit is sampled on a rising edge of sck, and only while cs_n is low. The most significant bit arrives first. Shift-clock activity while cs_n is high changes nothing.
- R3: A first word of the form 10xxxxxx loads register 1. Bits 5:4 are the duty code, bit 3 sets bias_half, and bits 2:0 are the port select.
- R4: A first word of the form 11xxxxxx loads register 2. Bit 5 is osc_ext, bit 4 is wave_b, bits 3:1 are contrast and bit 0 is disp_on.
- R5: A first word of the form 01xxxxxx loads the 6-bit pointer from bits 5:0. Bits 5:4 are the common index and bits 3:0 are the segment group. Each later word of the burst is written at the pointer, and the pointer then advances by one.
- R6: The pointer wraps from 63 to 0.
- R7: When the first word is a command word or has type 00, every later word in that burst changes neither the memory nor the configuration.
- R8: A word is committed on the falling edge of the 8th shift clock.
  - A rising edge of cs_n that ends a partial word of 1 to 7 bits commits it left-aligned, with the missing low bits set to 0.
  - A burst that carries no bits writes nothing.
- R9: Duty code 01 gives com_count = 3, code 10 gives 2, and codes 00 and 11 give 4.
- R10: A port select n in the range 0 to 4 sets the n highest bits of port_mask, counted from bit 3 downward. Values 5 to 7 give 0000.
- R11: If the 8th falling edge of sck and the rising edge of cs_n are seen in the same cycle, the word is committed exactly once.
- R12: rd_data always equals the stored byte at rd_addr, with no clock delay. Bit 7 belongs to the lowest-numbered segment of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | serial select, active low |
| sck | input | 1 | serial shift clock |
| sdi | input | 1 | serial data, MSB first |
| rd_addr | input | 6 | display memory read address |
| rd_data | output | 8 | display byte at rd_addr |
| com_count | output | 3 | number of active common lines (2, 3 or 4) |
| bias_half | output | 1 | 1 selects half bias, 0 selects third bias |
| port_mask | output | 4 | bit 3 is the highest segment; 1 means a general-purpose port |
| osc_ext | output | 1 | external oscillator selected |
| wave_b | output | 1 | waveform B selected |
| contrast | output | 3 | contrast code |
| disp_on | output | 1 | display enable |

## Verification
Two events can land in the same synchronised cycle: the falling edge of the 8th shift clock and the rising edge of select. Either one commits a word on its own. The bench provokes this by changing both pins in the same stimulus step after the eighth rising edge. It then judges the outcome through the read port. The addressed byte must hold the full word, and the following byte must still be zero, which proves the write happened exactly once. The same paths are also driven separately, once as a partial word closed by select and once as a complete word followed by a late select rise. A cycle-by-cycle model compares every output on every clock.

// File: rtl/lcd_if_pkg.sv
`timescale 1ns/1ps
package lcd_if_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_DATA  = 2'd2,
        ST_SKIP  = 2'd3
    } burst_st_t;

    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_ADDR = 2'b01,
        WK_CMD1 = 2'b10,
        WK_CMD2 = 2'b11
    } word_kind_t;

    // register 1 payload: duty code, bias, port select
    typedef struct packed {
        logic [1:0] duty;
        logic       bias;
        logic [2:0] psel;
    } cr1_t;

    // register 2 payload: oscillator source, waveform, contrast, enable
    typedef struct packed {
        logic       osc;
        logic       wave;
        logic [2:0] ctr;
        logic       disp;
    } cr2_t;

    localparam cr1_t CR1_DEFAULT = '0;
    localparam cr2_t CR2_DEFAULT = '0;

endpackage

// File: rtl/lcd_pin_sync.sv
`timescale 1ns/1ps
module lcd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_rise,
    output logic cs_fall,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_lvl
);
    // lane order: bit 0 select, bit 1 shift clock, bit 2 data
    localparam int         LANES    = 3;
    localparam logic [2:0] RST_PINS = 3'b001;

    logic [LANES-1:0] stage_q [STAGES];
    logic [1:0]       last_q;
    logic [LANES-1:0] sync_lvl;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_PINS;
                    else        stage_q[0] <= {sdi, sck, cs_n};
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_PINS;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_lvl = stage_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= RST_PINS[1:0];
        else        last_q <= sync_lvl[1:0];
    end

    assign cs_rise  =  sync_lvl[0] & ~last_q[0];
    assign cs_fall  = ~sync_lvl[0] &  last_q[0];
    assign sck_rise =  sync_lvl[1] & ~last_q[1];
    assign sck_fall = ~sync_lvl[1] &  last_q[1];
    assign sdi_lvl  =  sync_lvl[2];

endmodule

// File: rtl/lcd_word_fsm.sv
`timescale 1ns/1ps
module lcd_word_fsm
    import lcd_if_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_lvl,
    output burst_st_t         st,
    output logic              addr_ld,
    output logic              mem_we,
    output logic              cr1_we,
    output logic              cr2_we,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    burst_st_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              full_word;
    logic              word_done;
    logic              shift_en;
    word_kind_t        kind;

    assign full_word = (cnt_q == CNT_W'(WORD_W));
    // a word closes on the last falling clock, or early when select rises
    assign word_done = (st_q != ST_IDLE) &&
                       ((sck_fall && full_word) || (cs_rise && (cnt_q != '0)));
    assign shift_en  = (st_q != ST_IDLE) && !cs_rise && sck_rise && !full_word;
    assign word      = sh_q << (CNT_W'(WORD_W) - cnt_q);
    assign kind      = word_kind_t'(word[WORD_W-1 -: 2]);
    assign st        = st_q;

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (word_done) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= {sh_q[WORD_W-2:0], sdi_lvl};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cs_fall) st_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (cs_rise)        st_d = ST_IDLE;
                else if (word_done) st_d = (kind == WK_ADDR) ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                if (cs_rise) st_d = ST_IDLE;
            end
            ST_SKIP: begin
                if (cs_rise) st_d = ST_IDLE;
            end
        endcase
    end

    // actions
    always_comb begin
        addr_ld = 1'b0;
        mem_we  = 1'b0;
        cr1_we  = 1'b0;
        cr2_we  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_FIRST: begin
                if (word_done) begin
                    unique case (kind)
                        WK_ADDR: addr_ld = 1'b1;
                        WK_CMD1: cr1_we  = 1'b1;
                        WK_CMD2: cr2_we  = 1'b1;
                        WK_NONE: ;
                    endcase
                end
            end
            ST_DATA: mem_we = word_done;
            ST_SKIP: ;
        endcase
    end

endmodule

// File: rtl/lcd_disp_mem.sv
`timescale 1ns/1ps
module lcd_disp_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // pointer wraps naturally at its width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr_q <= '0;
        else if (addr_ld) ptr_q <= ld_val;
        else if (we)      ptr_q <= ptr_q + 1'b1;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (we && (ptr_q == ADDR_W'(g)))
                    mem_q[g] <= wdata;
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lcd_cfg_regs.sv
`timescale 1ns/1ps
module lcd_cfg_regs
    import lcd_if_pkg::*;
#(
    parameter int PAY_W = 6,
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cr1_we,
    input  logic             cr2_we,
    input  logic [PAY_W-1:0] payload,
    output logic [2:0]       com_count,
    output logic             bias_half,
    output logic [NPORT-1:0] port_mask,
    output logic             osc_ext,
    output logic             wave_b,
    output logic [2:0]       contrast,
    output logic             disp_on
);
    localparam int PSEL_W = $bits(cr1_t) - 3;

    cr1_t              cr1_q;
    cr2_t              cr2_q;
    logic [PSEL_W-1:0] n_ports;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cr1_q <= CR1_DEFAULT;
        else if (cr1_we) cr1_q <= cr1_t'(payload);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cr2_q <= CR2_DEFAULT;
        else if (cr2_we) cr2_q <= cr2_t'(payload);
    end

    always_comb begin
        unique case (cr1_q.duty)
            2'b01:   com_count = 3'd3;
            2'b10:   com_count = 3'd2;
            default: com_count = 3'd4;
        endcase
    end

    // out-of-range port select falls back to all segments
    assign n_ports = (cr1_q.psel <= PSEL_W'(NPORT)) ? cr1_q.psel : '0;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_port
            assign port_mask[i] = (n_ports > PSEL_W'(NPORT - 1 - i));
        end
    endgenerate

    assign bias_half = cr1_q.bias;
    assign osc_ext   = cr2_q.osc;
    assign wave_b    = cr2_q.wave;
    assign contrast  = cr2_q.ctr;
    assign disp_on   = cr2_q.disp;

endmodule

// File: rtl/lcd_serial_if.sv
`timescale 1ns/1ps
module lcd_serial_if
    import lcd_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8,
    parameter int NPORT       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic [WORD_W-3:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [2:0]        com_count,
    output logic              bias_half,
    output logic [NPORT-1:0]  port_mask,
    output logic              osc_ext,
    output logic              wave_b,
    output logic [2:0]        contrast,
    output logic              disp_on
);
    localparam int PAY_W = WORD_W - 2;

    logic              cs_rise, cs_fall, sck_rise, sck_fall, sdi_lvl;
    burst_st_t         fsm_st;
    logic              addr_ld, mem_we, cr1_we, cr2_we;
    logic [WORD_W-1:0] word;

    lcd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sdi      (sdi),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_lvl  (sdi_lvl)
    );

    lcd_word_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_lvl  (sdi_lvl),
        .st       (fsm_st),
        .addr_ld  (addr_ld),
        .mem_we   (mem_we),
        .cr1_we   (cr1_we),
        .cr2_we   (cr2_we),
        .word     (word)
    );

    lcd_disp_mem #(.ADDR_W(PAY_W), .DATA_W(WORD_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_ld (addr_ld),
        .ld_val  (word[PAY_W-1:0]),
        .we      (mem_we),
        .wdata   (word),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    lcd_cfg_regs #(.PAY_W(PAY_W), .NPORT(NPORT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cr1_we    (cr1_we),
        .cr2_we    (cr2_we),
        .payload   (word[PAY_W-1:0]),
        .com_count (com_count),
        .bias_half (bias_half),
        .port_mask (port_mask),
        .osc_ext   (osc_ext),
        .wave_b    (wave_b),
        .contrast  (contrast),
        .disp_on   (disp_on)
    );

endmodule

// File: rtl/lcd_serial_if_chk.sv
`timescale 1ns/1ps
module lcd_serial_if_chk
    import lcd_if_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input burst_st_t        st,
    input logic             cs_fall,
    input logic             addr_ld,
    input logic             mem_we,
    input logic             cr1_we,
    input logic             cr2_we,
    input logic [2:0]       com_count,
    input logic [NPORT-1:0] port_mask,
    input logic             bias_half,
    input logic             osc_ext,
    input logic             wave_b,
    input logic [2:0]       contrast,
    input logic             disp_on
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !cs_fall) |=> (st == ST_IDLE));

    // R5
    mem_write_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st == ST_DATA));

    // R5
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> (st == ST_DATA || st == ST_IDLE));

    // R7
    single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_ld, mem_we, cr1_we, cr2_we}));

    // R7
    cmd_then_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr1_we || cr2_we) |=> (st == ST_SKIP || st == ST_IDLE));

    // R3
    cr1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr1_we |=> $stable({com_count, port_mask, bias_half}));

    // R4
    cr2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr2_we |=> $stable({osc_ext, wave_b, contrast, disp_on}));

    // R9
    com_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_count >= 3'd2 && com_count <= 3'd4));

    // R10
    port_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_mask & ~{1'b1, port_mask[NPORT-1:1]}) == '0));

endmodule

bind lcd_serial_if lcd_serial_if_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (fsm_st),
    .cs_fall   (cs_fall),
    .addr_ld   (addr_ld),
    .mem_we    (mem_we),
    .cr1_we    (cr1_we),
    .cr2_we    (cr2_we),
    .com_count (com_count),
    .port_mask (port_mask),
    .bias_half (bias_half),
    .osc_ext   (osc_ext),
    .wave_b    (wave_b),
    .contrast  (contrast),
    .disp_on   (disp_on)
);

// File: tb/sim_lcd_serial_if.sv
`timescale 1ns/1ps
module sim_lcd_serial_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cur_cs = 1'b1, cur_sck = 1'b0, cur_sdi = 1'b0;
    logic [5:0] rd_a = '0;
    logic [7:0] rd_data;
    logic [2:0] com_count, contrast;
    logic       bias_half, osc_ext, wave_b, disp_on;
    logic [3:0] port_mask;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pend = 0;
    bit hold = 1'b0;
    bit run = 1'b0;

    // behavioural model: n_ = after latest stimulus, e_ = visible at ports
    int m_st = 0, m_cnt = 0, m_bits = 0, m_addr = 0;
    logic [7:0] n_mem [64];
    logic [7:0] e_mem [64];
    int n_duty = 0, n_bias = 0, n_psel = 0, n_osc = 0, n_wave = 0, n_ctr = 0, n_disp = 0;
    int e_duty = 0, e_bias = 0, e_psel = 0, e_osc = 0, e_wave = 0, e_ctr = 0, e_disp = 0;

    always #2.5 clk = ~clk;

    lcd_serial_if u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cur_cs),
        .sck       (cur_sck),
        .sdi       (cur_sdi),
        .rd_addr   (rd_a),
        .rd_data   (rd_data),
        .com_count (com_count),
        .bias_half (bias_half),
        .port_mask (port_mask),
        .osc_ext   (osc_ext),
        .wave_b    (wave_b),
        .contrast  (contrast),
        .disp_on   (disp_on)
    );

    function automatic int exp_com(int duty);
        if (duty == 1) return 3;
        if (duty == 2) return 2;
        return 4;
    endfunction

    function automatic int exp_mask(int psel);
        int n;
        n = (psel <= 4) ? psel : 0;
        return (((1 << n) - 1) << (4 - n)) & 15;
    endfunction

    function automatic void check(string tag, int got, int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at cycle %0d", tag, got, expv, cyc);
        end
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic model_step(input logic c, input logic s, input logic d);
        bit csr, csf, sr, sf, done;
        int w;
        csr = !cur_cs && c;
        csf = cur_cs && !c;
        sr  = !cur_sck && s;
        sf  = cur_sck && !s;
        done = (m_st != 0) && ((sf && m_cnt == 8) || (csr && m_cnt > 0));
        if (done) begin
            w = (m_bits << (8 - m_cnt)) & 255;
            if (m_st == 1) begin
                case (w >> 6)
                    1: begin m_addr = w & 63; m_st = 2; end
                    2: begin n_duty = (w >> 4) & 3; n_bias = (w >> 3) & 1; n_psel = w & 7; m_st = 3; end
                    3: begin n_osc = (w >> 5) & 1; n_wave = (w >> 4) & 1; n_ctr = (w >> 1) & 7; n_disp = w & 1; m_st = 3; end
                    default: m_st = 3;
                endcase
            end else if (m_st == 2) begin
                n_mem[m_addr] = w[7:0];
                m_addr = (m_addr + 1) % 64;
            end
            m_cnt = 0;
        end else if (m_st != 0 && !csr && sr && m_cnt < 8) begin
            m_bits = ((m_bits << 1) | int'(d)) & 255;
            m_cnt++;
        end
        if (csr) m_st = 0;
        if (csf) begin m_st = 1; m_cnt = 0; m_bits = 0; end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run) begin
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    e_mem = n_mem;
                    e_duty = n_duty; e_bias = n_bias; e_psel = n_psel;
                    e_osc = n_osc; e_wave = n_wave; e_ctr = n_ctr; e_disp = n_disp;
                end
            end
            check("R9 com_count", int'(com_count), exp_com(e_duty));
            check("R3 bias_half", int'(bias_half), e_bias);
            check("R10 port_mask", int'(port_mask), exp_mask(e_psel));
            check("R4 cr2 fields", int'({osc_ext, wave_b, contrast, disp_on}),
                  (e_osc << 5) | (e_wave << 4) | (e_ctr << 1) | e_disp);
            check("R5 rd_data", int'(rd_data), int'(e_mem[rd_a]));
            if (!hold) rd_a = rd_a + 6'd1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic drive(input logic c, input logic s, input logic d);
        @(posedge clk);
        #1;
        model_step(c, s, d);
        cur_cs = c; cur_sck = s; cur_sdi = d;
        pend = 4;
        repeat (4) @(posedge clk);
    endtask

    task automatic sel();
        drive(1'b0, 1'b0, 1'b0);
    endtask

    task automatic desel();
        drive(1'b1, 1'b0, 1'b0);
    endtask

    // send n bits MSB first, leaving the clock high after the last bit
    task automatic bits_hi(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            drive(1'b0, 1'b0, v[i]);
            drive(1'b0, 1'b1, v[i]);
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        bits_hi(v, 8);
        drive(1'b0, 1'b0, v[0]);
    endtask

    task automatic chk_mem(input int a, input int expv, input string tag);
        @(posedge clk);
        #1;
        hold = 1'b1;
        rd_a = a[5:0];
        @(negedge clk);
        check(tag, int'(rd_data), expv);
        hold = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin n_mem[i] = 8'h00; e_mem[i] = 8'h00; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        settle();
        // R1 reset defaults
        check("R1 com_count", int'(com_count), 4);
        check("R1 port_mask", int'(port_mask), 0);
        check("R1 flags", int'({bias_half, osc_ext, wave_b, contrast, disp_on}), 0);
        chk_mem(0, 0, "R1 mem[0]");
        chk_mem(63, 0, "R1 mem[63]");

        // R2 clock activity while deselected
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b1, 1'b1);
            drive(1'b1, 1'b0, 1'b1);
        end
        settle();
        check("R2 com_count", int'(com_count), 4);
        check("R2 disp_on", int'(disp_on), 0);
        chk_mem(0, 0, "R2 mem[0]");

        // R3 R9 R10 register 1
        sel(); send_byte(8'h9B); desel();
        settle();
        check("R9 duty 01", int'(com_count), 3);
        check("R3 bias", int'(bias_half), 1);
        check("R10 psel 3", int'(port_mask), 4'b1110);

        // R4 register 2
        sel(); send_byte(8'hFE); desel();
        settle();
        check("R4 fields", int'({osc_ext, wave_b, contrast, disp_on}), 6'b111110);
        sel(); send_byte(8'hC1); desel();
        settle();
        check("R4 enable", int'({osc_ext, wave_b, contrast, disp_on}), 6'b000001);

        // R5 address then stream
        sel(); send_byte(8'h52); send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h81); desel();
        chk_mem(18, 8'hA5, "R5 mem[18]");
        chk_mem(19, 8'h3C, "R5 mem[19]");
        chk_mem(20, 8'h81, "R5 mem[20]");
        chk_mem(18, 8'hA5, "R12 read port");

        // R6 wrap
        sel(); send_byte(8'h7E); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); desel();
        chk_mem(62, 8'h11, "R6 mem[62]");
        chk_mem(63, 8'h22, "R6 mem[63]");
        chk_mem(0, 8'h33, "R6 mem[0]");

        // R7 words after a command are dropped
        sel(); send_byte(8'h83); send_byte(8'hFF); send_byte(8'h55); desel();
        settle();
        check("R7 port_mask", int'(port_mask), 4'b1110);
        check("R7 com_count", int'(com_count), 4);
        check("R7 cr2 kept", int'({osc_ext, wave_b, contrast, disp_on}), 6'b000001);
        sel(); send_byte(8'h3F); send_byte(8'h12); desel();
        chk_mem(1, 0, "R7 type 00 mem[1]");
        chk_mem(0, 8'h33, "R7 type 00 mem[0]");

        // R9 R10 duty 11 and out-of-range select
        sel(); send_byte(8'hB5); desel();
        settle();
        check("R9 duty 11", int'(com_count), 4);
        check("R10 psel 5", int'(port_mask), 0);

        // R8 partial data word and empty burst
        sel(); send_byte(8'h45); bits_hi(8'hA0, 3); drive(1'b0, 1'b0, 1'b1); desel();
        chk_mem(5, 8'hA0, "R8 partial data");
        sel(); desel();
        chk_mem(5, 8'hA0, "R8 empty burst");
        chk_mem(6, 0, "R8 no extra write");
        // R8 partial first word 11 -> register 2 cleared
        sel(); bits_hi(8'hC0, 2); drive(1'b0, 1'b0, 1'b1); desel();
        settle();
        check("R8 partial command", int'({osc_ext, wave_b, contrast, disp_on}), 0);

        // R11 eighth falling clock together with select rising
        sel(); send_byte(8'h4A); bits_hi(8'h5A, 8); drive(1'b1, 1'b0, 1'b0);
        chk_mem(10, 8'h5A, "R11 coincident commit");
        chk_mem(11, 0, "R11 single write");

        repeat (10) @(posedge clk);
        finish_run();
    end

endmodule